// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block lets a processor send bytes to a slave on a two-wire serial bus as the only master. Software checks that the bus is free, selects the transmitting master role, and asks for a start. Once the start has gone out, the first byte it loads is the 7-bit slave address with the direction bit, and any data bytes follow. After each byte it reads back the acknowledge that the slave returned. When done, software asks for a stop, waits until the stop is seen on the wires, and hands the bus back.

The block has a holding register in front of a shift register, so software can load the next byte while the current one is still on the wire. Four status flags pace software: holding register empty, transfer finished, stop seen, and the received acknowledge. Both wires are open-drain. An output enable pulls a wire low, and the input pins return the resolved levels. The clock period is set by a divider register.

Top module: `iic_tx_master`

## Requirements
- R1: After reset both output enables are 0, the control register (address 0) and the status register (address 1) read 0, and the divider register (address 3) reads its reset value DIV_RST (4).
- R2: Bit 2 of a control-register read is a bus-busy status. It becomes 1 once a start condition (SDA falls while SCL is high) is seen on the inputs. It returns to 0 once a stop condition (SDA rises while SCL is high) is seen.
- R3: A control write with master (bit 0) = 1, transmit (bit 1) = 1 and busy (bit 2) = 1 issues a start, provided permit (bit 3) is 0 both in the stored register and in the written value, the bus is free and the engine is idle. A start means SDA is pulled low while SCL stays released, then SCL is pulled low. Status bit 0 (holding register empty) is set when the start completes.
- R4: While the stored permit bit is 1, a control write with busy = 1 has no effect: both wires stay released and bus-busy stays 0.
- R5: Each byte is sent most significant bit first, with one SCL high pulse per bit. SDA changes only while SCL is driven low, except for the falling SDA edge of a start and the rising SDA edge of a stop.
- R6: Every SCL high phase and every low phase between bits lasts DIV+1 clock cycles, where DIV is the divider register value.
- R7: A write to the transmit data register (address 2) clears status bit 0 on the next cycle. The bit is set again when the byte moves into the shift register.
- R8: Status bit 1 (transfer end) is set after the acknowledge clock of a byte only if no further byte is waiting. It stays 0 between back-to-back bytes, and a transmit data write clears it.
- R9: At the end of each acknowledge clock, the sampled SDA level is stored in status bit 3 (0 = acknowledged).
- R10: A control write with busy = 0 and permit = 0 while a transfer is held issues a stop. SCL is released with SDA low, then SDA is released. Status bit 2 is set once the stop is seen on the inputs, and both wires end up released.
- R11: Status bits 0 to 2 are cleared only by writing 0 to them after a status read that returned them as 1. Writing 0 without such a read leaves them unchanged, and writing 1 never changes them.
- R12: Whenever the engine is idle it drives neither wire, and after a stop a new start can be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (arms flag clearing) |
| cpu_addr | input | 2 | Register address: 0 control, 1 status, 2 transmit data, 3 divider |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench sends frames to a behavioural slave that refuses a wrong address, the read direction, and the data value 0xFF. A controller that stored the acknowledge at the wrong moment, or sent the bits in reverse order, would report the wrong acknowledge or deliver the wrong bytes. Back-to-back loading checks that transfer end stays 0 while a byte is waiting and that no byte is lost or repeated when the holding register is refilled mid-byte. Clearing a flag with no prior read, and a start request while the permit bit is set, both check that those writes are ignored. A second divider value checks that the SCL phases follow the register and are not fixed.

// File: rtl/iic_tx_pkg.sv
package iic_tx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI, ST_ALO, ST_AHI, ST_P2, ST_P3
  } eng_st_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
endpackage

// File: rtl/iic_line_mon.sv
module iic_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic bus_busy,
  output logic stop_det
);
  logic [2:0] scl_r, sda_r;
  logic       busy_q, busy_d;
  logic       start_det;

  // two synchronizer stages plus one history stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r  <= 3'b111;
      sda_r  <= 3'b111;
      busy_q <= 1'b0;
    end else begin
      scl_r  <= {scl_r[1:0], scl_in};
      sda_r  <= {sda_r[1:0], sda_in};
      busy_q <= busy_d;
    end
  end

  always_comb begin
    start_det = scl_r[1] && scl_r[2] && sda_r[2] && !sda_r[1];
    stop_det  = scl_r[1] && scl_r[2] && !sda_r[2] && sda_r[1];
    busy_d    = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  assign sda_s    = sda_r[1];
  assign bus_busy = busy_q;
endmodule

// File: rtl/iic_tx_fsm.sv
module iic_tx_fsm
  import iic_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              start_go,
  input  logic              stop_go,
  input  logic [BYTE_W-1:0] tdr,
  input  logic              tdr_full,
  input  logic              sda_s,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ld,
  output logic              start_done,
  output logic              tend_set,
  output logic              ack_we,
  output logic              eng_idle,
  output logic              edge_phase
);
  eng_st_t           st_q, st_d;
  logic [DIV_W-1:0]  tmr_q, tmr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              sp_q, sp_d;
  logic              tdone;

  assign tdone = (tmr_q == '0);

  always_comb begin
    st_d       = st_q;
    tmr_d      = tdone ? tmr_q : tmr_q - 1'b1;
    bit_d      = bit_q;
    sh_d       = sh_q;
    sp_d       = sp_q | stop_go;
    ld         = 1'b0;
    start_done = 1'b0;
    tend_set   = 1'b0;
    ack_we     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        tmr_d = div;
        sp_d  = 1'b0;
        if (start_go) st_d = ST_START;
      end
      ST_START: if (tdone) begin
        st_d       = ST_HOLD;
        tmr_d      = div;
        start_done = 1'b1;
      end
      ST_HOLD: if (tdone) begin
        if (tdr_full) begin
          st_d  = ST_BLO;
          tmr_d = div;
          ld    = 1'b1;
          sh_d  = tdr;
          bit_d = BIT_W'(BYTE_W - 1);
        end else if (sp_q) begin
          st_d  = ST_P2;
          tmr_d = div;
          sp_d  = 1'b0;
        end
      end
      ST_BLO: if (tdone) begin
        st_d  = ST_BHI;
        tmr_d = div;
      end
      ST_BHI: if (tdone) begin
        tmr_d = div;
        if (bit_q == '0) begin
          st_d = ST_ALO;
        end else begin
          st_d  = ST_BLO;
          bit_d = bit_q - 1'b1;
          sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
      ST_ALO: if (tdone) begin
        st_d  = ST_AHI;
        tmr_d = div;
      end
      ST_AHI: if (tdone) begin
        ack_we = 1'b1;
        tmr_d  = div;
        if (tdr_full) begin
          st_d  = ST_BLO;
          ld    = 1'b1;
          sh_d  = tdr;
          bit_d = BIT_W'(BYTE_W - 1);
        end else begin
          st_d     = ST_HOLD;
          tend_set = 1'b1;
        end
      end
      ST_P2: if (tdone) begin
        st_d  = ST_P3;
        tmr_d = div;
      end
      ST_P3: if (tdone) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      sp_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      sp_q  <= sp_d;
    end
  end

  // ack_we samples the synchronized SDA; the register block stores it
  logic unused_sda;
  assign unused_sda = sda_s;

  always_comb begin
    scl_oe = (st_q == ST_HOLD) || (st_q == ST_BLO) || (st_q == ST_ALO);
    unique case (st_q)
      ST_START, ST_HOLD, ST_P2: sda_oe = 1'b1;
      ST_BLO, ST_BHI:           sda_oe = ~sh_q[BYTE_W-1];
      default:                  sda_oe = 1'b0;
    endcase
  end

  assign eng_idle   = (st_q == ST_IDLE);
  assign edge_phase = (st_q == ST_START) || (st_q == ST_P3);
endmodule

// File: rtl/iic_tx_regs.sv
module iic_tx_regs
  import iic_tx_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              bus_busy,
  input  logic              stop_det,
  input  logic              eng_idle,
  input  logic              ld,
  input  logic              start_done,
  input  logic              tend_set,
  input  logic              ack_we,
  input  logic              ack_bit,
  output logic [DIV_W-1:0]  div,
  output logic [BYTE_W-1:0] tdr,
  output logic              tdr_full,
  output logic              start_go,
  output logic              stop_go,
  output logic              permit,
  output logic              txe,
  output logic              tend
);
  logic             master_q, xmit_q, permit_q;
  logic [DIV_W-1:0] div_q;
  logic [BYTE_W-1:0] tdr_q;
  logic             tfull_q, tfull_d;
  logic [2:0]       fl_q, fl_d, arm_q, arm_d, sw_clr;
  logic             ack_q;
  logic             wr_ctrl, wr_stat, wr_txd, wr_div, rd_stat;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_stat = we && (addr == A_STAT);
  assign wr_txd  = we && (addr == A_TXD);
  assign wr_div  = we && (addr == A_DIV);
  assign rd_stat = re && (addr == A_STAT);

  always_comb begin
    for (int i = 0; i < 3; i++) sw_clr[i] = wr_stat && !wdata[i] && arm_q[i];
    fl_d = fl_q;
    if (wr_txd)                 fl_d[0] = 1'b0;
    else if (ld || start_done)  fl_d[0] = 1'b1;
    else if (sw_clr[0])         fl_d[0] = 1'b0;
    if (wr_txd)                 fl_d[1] = 1'b0;
    else if (tend_set)          fl_d[1] = 1'b1;
    else if (sw_clr[1])         fl_d[1] = 1'b0;
    if (stop_det)               fl_d[2] = 1'b1;
    else if (sw_clr[2])         fl_d[2] = 1'b0;
    arm_d   = rd_stat ? fl_q : (arm_q & fl_d);
    tfull_d = wr_txd ? 1'b1 : (ld ? 1'b0 : tfull_q);
    start_go = wr_ctrl && wdata[2] && wdata[1] && wdata[0] && !wdata[3]
               && !permit_q && !bus_busy && eng_idle;
    stop_go  = wr_ctrl && !wdata[2] && !wdata[3] && !permit_q && !eng_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      xmit_q   <= 1'b0;
      permit_q <= 1'b0;
      div_q    <= DIV_RST;
      tdr_q    <= '0;
      tfull_q  <= 1'b0;
      fl_q     <= '0;
      arm_q    <= '0;
      ack_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        master_q <= wdata[0];
        xmit_q   <= wdata[1];
        permit_q <= wdata[3];
      end
      if (wr_div) div_q <= wdata[DIV_W-1:0];
      if (wr_txd) tdr_q <= wdata;
      if (ack_we) ack_q <= ack_bit;
      tfull_q <= tfull_d;
      fl_q    <= fl_d;
      arm_q   <= arm_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {4'b0, permit_q, bus_busy, xmit_q, master_q};
      A_STAT:  rdata = {4'b0, ack_q, fl_q};
      A_TXD:   rdata = tdr_q;
      default: rdata = 8'(div_q);
    endcase
  end

  assign div      = div_q;
  assign tdr      = tdr_q;
  assign tdr_full = tfull_q;
  assign permit   = permit_q;
  assign txe      = fl_q[0];
  assign tend     = fl_q[1];
endmodule

// File: rtl/iic_tx_master.sv
module iic_tx_master
  import iic_tx_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_we,
  input  logic       cpu_re,
  input  logic [1:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic [1:0]        rs_q;
  logic              rst_i;
  logic              sda_s, bus_busy, stop_det;
  logic [DIV_W-1:0]  div;
  logic [BYTE_W-1:0] tdr;
  logic              tdr_full, start_go, stop_go, permit, txe, tend;
  logic              ld, start_done, tend_set, ack_we, eng_idle, edge_phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  iic_line_mon u_mon (
    .clk(clk), .rst_n(rst_i), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .bus_busy(bus_busy), .stop_det(stop_det)
  );

  iic_tx_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_i), .we(cpu_we), .re(cpu_re), .addr(cpu_addr),
    .wdata(cpu_wdata), .rdata(cpu_rdata), .bus_busy(bus_busy),
    .stop_det(stop_det), .eng_idle(eng_idle), .ld(ld),
    .start_done(start_done), .tend_set(tend_set), .ack_we(ack_we),
    .ack_bit(sda_s), .div(div), .tdr(tdr), .tdr_full(tdr_full),
    .start_go(start_go), .stop_go(stop_go), .permit(permit),
    .txe(txe), .tend(tend)
  );

  iic_tx_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk(clk), .rst_n(rst_i), .div(div), .start_go(start_go),
    .stop_go(stop_go), .tdr(tdr), .tdr_full(tdr_full), .sda_s(sda_s),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ld(ld), .start_done(start_done),
    .tend_set(tend_set), .ack_we(ack_we), .eng_idle(eng_idle),
    .edge_phase(edge_phase)
  );
endmodule

// File: rtl/iic_tx_master_chk.sv
module iic_tx_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_i,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             eng_idle,
  input logic             edge_phase,
  input logic             permit,
  input logic [DIV_W-1:0] div,
  input logic             cpu_we,
  input logic [1:0]       cpu_addr,
  input logic             txe,
  input logic             tend,
  input logic             ld
);
  localparam int RUN_W = DIV_W + 2;
  logic [RUN_W-1:0] run_q;
  logic             prev_scl;

  // length of the current SCL output phase, saturating
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      prev_scl <= 1'b0;
      run_q    <= '1;
    end else begin
      prev_scl <= scl_oe;
      if (scl_oe != prev_scl) run_q <= RUN_W'(1);
      else if (run_q != '1)   run_q <= run_q + 1'b1;
    end
  end

  assert_sda_only_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> edge_phase);

  assert_scl_phase_len_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (scl_oe != prev_scl) |-> (run_q >= (RUN_W'(div) + 1'b1)));

  assert_txd_write_clears_txe_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (cpu_we && cpu_addr == 2'd2) |=> !txe);

  assert_no_tend_on_load_R8: assert property (@(posedge clk) disable iff (!rst_i)
    ld |=> !tend);

  assert_permit_blocks_start_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (eng_idle && permit) |=> eng_idle);

  assert_idle_releases_lines_R12: assert property (@(posedge clk) disable iff (!rst_i)
    eng_idle |-> (!scl_oe && !sda_oe));
endmodule

bind iic_tx_master iic_tx_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .eng_idle(eng_idle), .edge_phase(edge_phase), .permit(permit), .div(div),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .txe(txe), .tend(tend), .ld(ld)
);

// File: tb/sim_iic_tx_master.sv
module sim_iic_tx_master;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we, re;
  logic [1:0] addr;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  wire        scl_oe, sda_oe;
  logic       s_drv;
  wire        scl_w = ~scl_oe;
  wire        sda_w = ~(sda_oe | s_drv);

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iic_tx_master u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(we), .cpu_re(re), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // behavioural slave at address 0x2D, write only, refuses data 0xFF
  logic [7:0] rx [8];
  int   nrx = 0, nstart = 0, nstop = 0, bitn = 0, hi_cnt = 0, lo_cnt = 0;
  int   hi_last = 0, lo_last = 0;
  logic [7:0] shr;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_drv = 1'b0; bitn = 0;
    end else begin
      if (p_scl && scl_w && p_sda && !sda_w) begin nstart++; nrx = 0; bitn = 0; end
      if (p_scl && scl_w && !p_sda && sda_w) nstop++;
      if (!p_scl && scl_w) begin
        if (bitn >= 1 && bitn <= 7) lo_last = lo_cnt;
        if (bitn < 8) begin shr = {shr[6:0], sda_w}; bitn++; end
        else if (bitn == 8) bitn = 9;
      end
      if (p_scl && !scl_w) begin
        if (bitn >= 1 && bitn <= 8) hi_last = hi_cnt;
        if (bitn == 8) begin
          if (nrx < 8) rx[nrx] = shr;
          s_drv = (nrx == 0) ? (shr == 8'h5A) : (shr != 8'hFF);
          nrx++;
        end else if (bitn == 9) begin
          s_drv = 1'b0; bitn = 0;
        end
      end
      hi_cnt = scl_w ? hi_cnt + 1 : 0;
      lo_cnt = scl_w ? 0 : lo_cnt + 1;
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  // {address byte, data byte, expected address ack, expected data ack}
  localparam logic [17:0] VEC [6] = '{
    {8'h5A, 8'h3C, 1'b0, 1'b0},
    {8'h5A, 8'hFF, 1'b0, 1'b1},
    {8'h5B, 8'h00, 1'b1, 1'b0},
    {8'h22, 8'h00, 1'b1, 1'b0},
    {8'h5A, 8'h81, 1'b0, 1'b0},
    {8'h5A, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic poll(input int pos, output logic [7:0] st);
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, st);
      if (st[pos]) return;
    end
    chk(1'b0, "poll timeout", pos, 1);
  endtask

  task automatic finish_frame();
    logic [7:0] v;
    int ns;
    wr(2'd1, 8'h0D);
    rd(2'd1, v);
    chk(v[1] == 1'b0, "R11 tend cleared after read", v[1], 0);
    ns = nstop;
    wr(2'd0, 8'h03);
    poll(2, v);
    chk(!scl_oe && !sda_oe, "R10 lines released after stop", {scl_oe, sda_oe}, 0);
    chk(nstop == ns + 1, "R10 stop seen by slave", nstop, ns + 1);
    rd(2'd0, v);
    chk(v[2] == 1'b0, "R2 busy cleared by stop", v[2], 0);
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    chk(v[2:0] == 3'b000, "R11 flags cleared", v[2:0], 0);
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] d,
                           input logic ea, input logic ed);
    logic [7:0] v, st;
    int ns;
    rd(2'd0, v);
    chk(v[2] == 1'b0, "R2 bus free before start", v[2], 0);
    ns = nstart;
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h07);
    poll(0, st);
    chk(st[0] == 1'b1, "R3 txe after start", st[0], 1);
    chk(nstart == ns + 1, "R12 R3 start seen", nstart, ns + 1);
    rd(2'd0, v);
    chk(v[2] == 1'b1, "R2 busy after start", v[2], 1);
    wr(2'd2, a);
    poll(1, st);
    chk(st[3] == ea, "R9 address ack", st[3], ea);
    chk(rx[0] == a, "R5 address byte", rx[0], a);
    if (!ea) begin
      wr(2'd2, d);
      poll(1, st);
      chk(st[3] == ed, "R9 data ack", st[3], ed);
      chk(rx[1] == d, "R5 data byte", rx[1], d);
    end
    chk(hi_last == 5, "R6 high phase", hi_last, 5);
    chk(lo_last == 5, "R6 low phase", lo_last, 5);
    finish_frame();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, st;
    we = 1'b0; re = 1'b0; addr = 2'd0; wdata = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 outputs released", {scl_oe, sda_oe}, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 control reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 0);
    rd(2'd3, v); chk(v == 8'h04, "R1 divider reset", v, 4);

    // R4 permit bit blocks start
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h0F);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R4 no start with permit set", {scl_oe, sda_oe}, 0);
    rd(2'd0, v); chk(v[2] == 1'b0, "R4 bus stays free", v[2], 0);
    wr(2'd0, 8'h00);

    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);

    // back-to-back bytes, other divider, clear without read
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h07);
    repeat (40) @(posedge clk);
    wr(2'd1, 8'h00);
    rd(2'd1, st);
    chk(st[0] == 1'b1, "R11 clear without read ignored", st[0], 1);
    wr(2'd1, 8'h00);
    rd(2'd1, st);
    chk(st[0] == 1'b0, "R11 clear after read", st[0], 0);
    wr(2'd2, 8'h5A);
    poll(0, st);
    chk(st[0] == 1'b1, "R7 txe set on load", st[0], 1);
    wr(2'd2, 8'h12);
    rd(2'd1, st);
    chk(st[0] == 1'b0, "R7 txe cleared by write", st[0], 0);
    poll(0, st);
    chk(st[1] == 1'b0, "R8 no tend while byte waits", st[1], 0);
    wr(2'd2, 8'h34);
    poll(1, st);
    chk(st[3] == 1'b0, "R9 last byte acked", st[3], 0);
    chk(nrx == 3, "R8 three bytes sent", nrx, 3);
    chk(rx[1] == 8'h12 && rx[2] == 8'h34, "R5 byte order", {rx[1], rx[2]}, 16'h1234);
    chk(hi_last == 3, "R6 high phase div 2", hi_last, 3);
    chk(lo_last == 3, "R6 low phase div 2", lo_last, 3);
    finish_frame();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule